// File: doc/BRIEF.md
# Prioritized Trap and Interrupt Entry Sequencer

This block is the exception-entry controller of a 16-bit processor core. It keeps a flag register of outstanding requests from three internal traps (extended-instruction, privileged-instruction, system call), a segment trap and three external interrupts (non-maskable, non-vectored, vectored). Requests are taken only when the core signals an instruction boundary. At that point the sequencer picks the most urgent eligible request and runs the entry sequence, with the core stalled on `busy_o`.

For the segment trap and the external interrupts, the sequencer first runs an acknowledge cycle and captures a 16-bit identifier from the bus. For the internal traps, the identifier is the first word of the instruction that caused the trap. The sequencer then emits three stack pushes: return PC, the status word as it was before entry, and the identifier. Next it reads the new status word and new PC from the slot of that source in a program-status area. The vectored interrupt is the exception: its PC comes from a vector table indexed by the identifier's low byte. Both values are handed to the core together in a single commit cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: `pending_o` is 0 after reset. Every bit set in `req_set_i` is ORed into it on the next edge, with this encoding: 0x80 extended trap, 0x40 privileged trap, 0x20 non-maskable, 0x10 segment trap, 0x08 non-vectored, 0x04 vectored, 0x02 system call. Bit 0 is reserved and never becomes set.
- R2: A request is taken only on a cycle where `boundary_i` is high while the block is idle. `busy_o` rises on the next cycle and stays high up to and including the commit cycle.
- R3: When several requests are eligible, the service order is: extended trap, privileged trap, system call, segment trap, non-maskable, non-vectored, vectored.
- R4: The non-vectored request is eligible only if `status_i[11]` is set, and the vectored request only if `status_i[12]` is set. All traps and the non-maskable request ignore both bits. A masked request stays pending.
- R5: Taking a request clears only its own flag. Flags set while the block is busy, or in the cycle a request is taken, are kept.
- R6: The entry sequence pushes three words in three consecutive cycles on `push_valid_o`/`push_data_o`, in this order: the `pc_i` value at the boundary, the `status_i` value at the boundary, and the identifier.
- R7: For the extended trap, the privileged trap and the system call, the identifier is `instr_word_i` as sampled at the boundary, and no acknowledge cycle occurs.
- R8: For the segment trap and the three external interrupts, `ack_req_o` is held with `ack_src_o` set as follows: 0 segment, 1 non-maskable, 2 non-vectored, 3 vectored. It stays up until `ack_valid_i` is high. The identifier is then `ack_data_i` when `ack_drive_i` is high, and 0xFFFF otherwise.
- R9: The new status word is read from `PSA_BASE + 4*k`, and the new PC from `PSA_BASE + 4*k + 2`. The source index k is: extended 0, privileged 1, system call 2, segment 3, non-maskable 4, non-vectored 5, vectored 6.
- R10: For the vectored interrupt, the new PC is read from `VEC_BASE + 2*id[7:0]` instead of its slot.
- R11: Each read holds `mem_req_o` and `mem_addr_o` until `mem_valid_i` is high. `commit_o` is high for exactly one cycle after both reads, with `new_status_o` and `new_pc_o` showing the two read values (both outputs are 0 outside commit).
- R12: `halt_clr_o` pulses during the first push for the non-maskable, non-vectored and vectored interrupts only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| req_set_i | input | 8 | Request flags to OR into the pending register |
| pc_i | input | W | Return PC of the current boundary |
| status_i | input | W | Current status word (bit 11 non-vectored enable, bit 12 vectored enable) |
| instr_word_i | input | W | First word of the current instruction |
| ack_req_o | output | 1 | Acknowledge cycle in progress |
| ack_src_o | output | 2 | Acknowledged source code |
| ack_valid_i | input | 1 | Acknowledge cycle completes |
| ack_drive_i | input | 1 | A device drives the bus during acknowledge |
| ack_data_i | input | W | Acknowledge bus word |
| push_valid_o | output | 1 | Stack push strobe |
| push_data_o | output | W | Word to push |
| mem_req_o | output | 1 | Program-status / vector read request |
| mem_addr_o | output | W | Read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | W | Read data |
| commit_o | output | 1 | New status and PC valid |
| new_status_o | output | W | New status word |
| new_pc_o | output | W | New PC |
| busy_o | output | 1 | Core must stall |
| halt_clr_o | output | 1 | Leave the halted state |
| pending_o | output | 8 | Pending request flags |

## Verification
The hardest situation to reach from the ports is a request arriving while another entry is half done: a new flag is raised while the block waits on a stretched acknowledge or a slow memory read, and it must survive the clear of the flag being serviced. The stimulus raises a privileged trap in the middle of a vectored-interrupt entry and stretches the acknowledge and read latencies. It also offers a masked non-vectored request at a boundary and then enables it with no device driving the bus, so the 0xFFFF identifier appears. A behavioural model in the bench follows every cycle and checks every output.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        SRC_EXT  = 3'd0,
        SRC_PRIV = 3'd1,
        SRC_SYSC = 3'd2,
        SRC_SEG  = 3'd3,
        SRC_NMI  = 3'd4,
        SRC_NVI  = 3'd5,
        SRC_VI   = 3'd6
    } src_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ACK, PH_PUSH_PC, PH_PUSH_SW,
        PH_PUSH_ID, PH_LD_SW, PH_LD_PC, PH_COMMIT
    } phase_e;

    localparam int FLAG_W = 8;

    function automatic logic [FLAG_W-1:0] src_flag(src_e s);
        case (s)
            SRC_EXT:  return 8'h80;
            SRC_PRIV: return 8'h40;
            SRC_NMI:  return 8'h20;
            SRC_SEG:  return 8'h10;
            SRC_NVI:  return 8'h08;
            SRC_VI:   return 8'h04;
            SRC_SYSC: return 8'h02;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic needs_ack(src_e s);
        return (s == SRC_SEG) || (s == SRC_NMI) || (s == SRC_NVI) || (s == SRC_VI);
    endfunction

    function automatic logic [1:0] ack_code(src_e s);
        case (s)
            SRC_NMI: return 2'd1;
            SRC_NVI: return 2'd2;
            SRC_VI:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_pick.sv
module exc_pick
    import exc_pkg::*;
(
    input  logic [7:1] pend_i,
    input  logic       nvi_en_i,
    input  logic       vi_en_i,
    output logic       hit_o,
    output src_e       src_o
);
    always_comb begin
        hit_o = 1'b1;
        src_o = SRC_EXT;
        if (pend_i[7])                 src_o = SRC_EXT;
        else if (pend_i[6])            src_o = SRC_PRIV;
        else if (pend_i[1])            src_o = SRC_SYSC;
        else if (pend_i[4])            src_o = SRC_SEG;
        else if (pend_i[5])            src_o = SRC_NMI;
        else if (pend_i[3] && nvi_en_i) src_o = SRC_NVI;
        else if (pend_i[2] && vi_en_i)  src_o = SRC_VI;
        else                           hit_o = 1'b0;
    end
endmodule

// File: rtl/exc_addr.sv
module exc_addr
    import exc_pkg::*;
#(
    parameter int          W        = 16,
    parameter int unsigned PSA_BASE = 16'h0100,
    parameter int unsigned VEC_BASE = 16'h0200
) (
    input  src_e         src_i,
    input  logic         sel_pc_i,
    input  logic [7:0]   id_lo_i,
    output logic [W-1:0] addr_o
);
    localparam logic [W-1:0] PSA = W'(PSA_BASE);
    localparam logic [W-1:0] VEC = W'(VEC_BASE);

    logic [W-1:0] slot;

    always_comb begin
        slot = PSA + W'({src_i, 2'b00});
        if (sel_pc_i && src_i == SRC_VI)
            addr_o = VEC + W'({id_lo_i, 1'b0});
        else if (sel_pc_i)
            addr_o = slot + W'(2);
        else
            addr_o = slot;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int          W        = 16,
    parameter int unsigned PSA_BASE = 16'h0100,
    parameter int unsigned VEC_BASE = 16'h0200,
    parameter int          NVIE_BIT = 11,
    parameter int          VIE_BIT  = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         boundary_i,
    input  logic [7:0]   req_set_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] instr_word_i,
    output logic         ack_req_o,
    output logic [1:0]   ack_src_o,
    input  logic         ack_valid_i,
    input  logic         ack_drive_i,
    input  logic [W-1:0] ack_data_i,
    output logic         push_valid_o,
    output logic [W-1:0] push_data_o,
    output logic         mem_req_o,
    output logic [W-1:0] mem_addr_o,
    input  logic         mem_valid_i,
    input  logic [W-1:0] mem_data_i,
    output logic         commit_o,
    output logic [W-1:0] new_status_o,
    output logic [W-1:0] new_pc_o,
    output logic         busy_o,
    output logic         halt_clr_o,
    output logic [7:0]   pending_o
);
    localparam logic [7:0]   SET_MASK = 8'hFE;
    localparam logic [W-1:0] OPEN_BUS = '1;

    typedef struct packed {
        phase_e       ph;
        src_e         src;
        logic [7:0]   pend;
        logic [W-1:0] pc;
        logic [W-1:0] sw;
        logic [W-1:0] id;
        logic [W-1:0] nsw;
        logic [W-1:0] npc;
    } seq_t;

    seq_t s_q, s_d;

    logic pick_hit;
    src_e pick_src;

    exc_pick u_pick (
        .pend_i   (s_q.pend[7:1]),
        .nvi_en_i (status_i[NVIE_BIT]),
        .vi_en_i  (status_i[VIE_BIT]),
        .hit_o    (pick_hit),
        .src_o    (pick_src)
    );

    exc_addr #(.W(W), .PSA_BASE(PSA_BASE), .VEC_BASE(VEC_BASE)) u_addr (
        .src_i    (s_q.src),
        .sel_pc_i (s_q.ph == PH_LD_PC),
        .id_lo_i  (s_q.id[7:0]),
        .addr_o   (mem_addr_o)
    );

    always_comb begin
        logic [7:0] clr;
        s_d = s_q;
        clr = '0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (boundary_i && pick_hit) begin
                    clr     = src_flag(pick_src);
                    s_d.src = pick_src;
                    s_d.pc  = pc_i;
                    s_d.sw  = status_i;
                    s_d.id  = instr_word_i;
                    s_d.ph  = needs_ack(pick_src) ? PH_ACK : PH_PUSH_PC;
                end
            end
            PH_ACK: begin
                if (ack_valid_i) begin
                    s_d.id = ack_drive_i ? ack_data_i : OPEN_BUS;
                    s_d.ph = PH_PUSH_PC;
                end
            end
            PH_PUSH_PC: s_d.ph = PH_PUSH_SW;
            PH_PUSH_SW: s_d.ph = PH_PUSH_ID;
            PH_PUSH_ID: s_d.ph = PH_LD_SW;
            PH_LD_SW: begin
                if (mem_valid_i) begin
                    s_d.nsw = mem_data_i;
                    s_d.ph  = PH_LD_PC;
                end
            end
            PH_LD_PC: begin
                if (mem_valid_i) begin
                    s_d.npc = mem_data_i;
                    s_d.ph  = PH_COMMIT;
                end
            end
            PH_COMMIT: s_d.ph = PH_IDLE;
            default:   s_d.ph = PH_IDLE;
        endcase
        s_d.pend = (s_q.pend | (req_set_i & SET_MASK)) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, src: SRC_EXT, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy_o       = (s_q.ph != PH_IDLE);
        ack_req_o    = (s_q.ph == PH_ACK);
        ack_src_o    = ack_code(s_q.src);
        push_valid_o = (s_q.ph == PH_PUSH_PC) || (s_q.ph == PH_PUSH_SW) || (s_q.ph == PH_PUSH_ID);
        unique case (s_q.ph)
            PH_PUSH_PC: push_data_o = s_q.pc;
            PH_PUSH_SW: push_data_o = s_q.sw;
            PH_PUSH_ID: push_data_o = s_q.id;
            default:    push_data_o = '0;
        endcase
        halt_clr_o   = (s_q.ph == PH_PUSH_PC) &&
                       (s_q.src == SRC_NMI || s_q.src == SRC_NVI || s_q.src == SRC_VI);
        mem_req_o    = (s_q.ph == PH_LD_SW) || (s_q.ph == PH_LD_PC);
        commit_o     = (s_q.ph == PH_COMMIT);
        new_status_o = commit_o ? s_q.nsw : '0;
        new_pc_o     = commit_o ? s_q.npc : '0;
        pending_o    = s_q.pend;
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         boundary_i,
    input logic         ack_req_o,
    input logic [1:0]   ack_src_o,
    input logic         ack_valid_i,
    input logic         push_valid_o,
    input logic         mem_req_o,
    input logic [W-1:0] mem_addr_o,
    input logic         mem_valid_i,
    input logic         commit_o,
    input logic         busy_o,
    input logic         halt_clr_o,
    input logic [7:0]   pending_o
);
    AST_RSVD_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o[0]); // R1

    AST_TRAP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && boundary_i && (pending_o & 8'hF2) != 8'h00) |=> busy_o); // R2

    AST_PUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid_o |-> busy_o); // R2

    AST_PUSH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_valid_o) |=> push_valid_o); // R6

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && !ack_valid_i) |=> (ack_req_o && $stable(ack_src_o))); // R8

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R11

    AST_COMMIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (!commit_o && !busy_o)); // R11

    AST_HALT_IN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        halt_clr_o |-> push_valid_o); // R12
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_i   (boundary_i),
    .ack_req_o    (ack_req_o),
    .ack_src_o    (ack_src_o),
    .ack_valid_i  (ack_valid_i),
    .push_valid_o (push_valid_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_valid_i  (mem_valid_i),
    .commit_o     (commit_o),
    .busy_o       (busy_o),
    .halt_clr_o   (halt_clr_o),
    .pending_o    (pending_o)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
    localparam int W = 16;
    localparam logic [15:0] PSA = 16'h0100;
    localparam logic [15:0] VEC = 16'h0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary_i = 1'b0;
    logic [7:0] req_set_i = '0;
    logic [W-1:0] pc_i = '0, status_i = '0, instr_word_i = '0;
    logic ack_req_o; logic [1:0] ack_src_o;
    logic ack_valid_i = 1'b0, ack_drive_i = 1'b1;
    logic [W-1:0] ack_data_i = '0;
    logic push_valid_o; logic [W-1:0] push_data_o;
    logic mem_req_o; logic [W-1:0] mem_addr_o;
    logic mem_valid_i = 1'b0; logic [W-1:0] mem_data_i = '0;
    logic commit_o; logic [W-1:0] new_status_o, new_pc_o;
    logic busy_o, halt_clr_o; logic [7:0] pending_o;

    always #4 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (.*);

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int ack_wait = 0, mem_wait = 0, ack_cnt = 0, mem_cnt = 0;
    logic [15:0] pushq[$];
    logic [15:0] addrq[$];

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8]};
    endfunction

    // behavioural reference model
    int m_ph = 0, m_src = 0;
    logic [7:0] m_pend = '0;
    logic [15:0] m_pc = '0, m_sw = '0, m_id = '0, m_nsw = '0, m_npc = '0;

    function automatic int pick(input logic [7:0] p, input logic [15:0] sw);
        if (p[7]) return 0;
        if (p[6]) return 1;
        if (p[1]) return 2;
        if (p[4]) return 3;
        if (p[5]) return 4;
        if (p[3] && sw[11]) return 5;
        if (p[2] && sw[12]) return 6;
        return -1;
    endfunction

    function automatic logic [7:0] flag_of(input int s);
        logic [7:0] t [7] = '{8'h80, 8'h40, 8'h02, 8'h10, 8'h20, 8'h08, 8'h04};
        return t[s];
    endfunction

    function automatic logic [15:0] addr_exp(input int ph, input int s, input logic [15:0] id);
        if (ph == 6 && s == 6) return VEC + {7'd0, id[7:0], 1'b0};
        return PSA + 16'(4 * s) + ((ph == 6) ? 16'd2 : 16'd0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pend = '0;
        end else begin
            logic [7:0] np;
            int p;
            np = m_pend | (req_set_i & 8'hFE);
            case (m_ph)
                0: if (boundary_i) begin
                    p = pick(m_pend, status_i);
                    if (p >= 0) begin
                        np = np & ~flag_of(p);
                        m_src = p; m_pc = pc_i; m_sw = status_i; m_id = instr_word_i;
                        m_ph = (p >= 3) ? 1 : 2;
                    end
                end
                1: if (ack_valid_i) begin
                    m_id = ack_drive_i ? ack_data_i : 16'hFFFF;
                    m_ph = 2;
                end
                2, 3, 4: m_ph = m_ph + 1;
                5: if (mem_valid_i) begin m_nsw = memf(addr_exp(5, m_src, m_id)); m_ph = 6; end
                6: if (mem_valid_i) begin m_npc = memf(addr_exp(6, m_src, m_id)); m_ph = 7; end
                default: m_ph = 0;
            endcase
            m_pend = np;
            if (push_valid_o) pushq.push_back(push_data_o);
            if (mem_req_o && mem_valid_i) addrq.push_back(mem_addr_o);
        end
    end

    // per-cycle comparison, then responders
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] pd;
            pd = (m_ph == 2) ? m_pc : (m_ph == 3) ? m_sw : m_id;
            check(pending_o == m_pend, "R1/R5 pending", {8'h0, pending_o}, {8'h0, m_pend});
            check(busy_o == (m_ph != 0), "R2 busy", 16'(busy_o), 16'(m_ph != 0));
            check(push_valid_o == (m_ph >= 2 && m_ph <= 4), "R6 push strobe", 16'(push_valid_o), 16'(m_ph >= 2 && m_ph <= 4));
            if (m_ph >= 2 && m_ph <= 4)
                check(push_data_o == pd, (m_ph == 4) ? "R7/R8 identifier" : "R6 push word", push_data_o, pd);
            check(ack_req_o == (m_ph == 1), "R8 ack req", 16'(ack_req_o), 16'(m_ph == 1));
            if (m_ph == 1)
                check(ack_src_o == 2'(m_src - 3), "R8 ack src", 16'(ack_src_o), 16'(m_src - 3));
            check(mem_req_o == (m_ph == 5 || m_ph == 6), "R11 read req", 16'(mem_req_o), 16'(m_ph == 5 || m_ph == 6));
            if (m_ph == 5 || m_ph == 6)
                check(mem_addr_o == addr_exp(m_ph, m_src, m_id), "R9/R10 read addr", mem_addr_o, addr_exp(m_ph, m_src, m_id));
            check(commit_o == (m_ph == 7), "R11 commit", 16'(commit_o), 16'(m_ph == 7));
            check(new_pc_o == ((m_ph == 7) ? m_npc : 16'h0), "R11 new pc", new_pc_o, (m_ph == 7) ? m_npc : 16'h0);
            check(new_status_o == ((m_ph == 7) ? m_nsw : 16'h0), "R11 new status", new_status_o, (m_ph == 7) ? m_nsw : 16'h0);
            check(halt_clr_o == (m_ph == 2 && m_src >= 4), "R12 halt clear", 16'(halt_clr_o), 16'(m_ph == 2 && m_src >= 4));
        end
        if (ack_req_o) begin
            ack_valid_i <= (ack_cnt >= ack_wait);
            ack_cnt++;
        end else begin ack_valid_i <= 1'b0; ack_cnt = 0; end
        if (mem_req_o && !mem_valid_i) begin
            mem_valid_i <= (mem_cnt >= mem_wait);
            mem_data_i  <= memf(mem_addr_o);
            mem_cnt++;
        end else begin mem_valid_i <= 1'b0; mem_cnt = 0; end
    end

    task automatic raise(input logic [7:0] f);
        @(negedge clk) req_set_i = f;
        @(negedge clk) req_set_i = '0;
    endtask

    task automatic bound(input logic [15:0] sw);
        @(negedge clk) begin status_i = sw; boundary_i = 1'b1; end
        @(negedge clk) boundary_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pending_o == 8'h00 && !busy_o, "R1 reset state", {8'h0, pending_o}, 16'h0);
        rst_n = 1'b1;

        // R7: privileged trap pushes the instruction word
        pc_i = 16'h1234; instr_word_i = 16'h7F22;
        raise(8'h40); bound(16'h0000); wait_idle();
        check(pushq.size() >= 3 && pushq[pushq.size()-1] == 16'h7F22, "R7 trap id",
              pushq[pushq.size()-1], 16'h7F22);

        // R3: ext + sys + seg + nmi together, enables off
        ack_data_i = 16'h5501; ack_wait = 1;
        raise(8'hB2);
        for (int i = 0; i < 4; i++) begin
            addrq.delete();
            bound(16'h0000); wait_idle();
            check(addrq.size() == 2 && addrq[0] == PSA + 16'(4 * ((i == 0) ? 0 : i + 1)),
                  "R3 service order", addrq[0], PSA + 16'(4 * ((i == 0) ? 0 : i + 1)));
        end

        // R4: masked non-vectored stays pending
        raise(8'h08); bound(16'h0000); @(negedge clk);
        check(!busy_o && pending_o[3], "R4 masked nvi", {8'h0, pending_o}, 16'h0008);
        // R8: open bus gives all ones
        ack_drive_i = 1'b0; ack_wait = 2;
        bound(16'h0800); wait_idle();
        check(pushq[pushq.size()-1] == 16'hFFFF, "R8 open bus id", pushq[pushq.size()-1], 16'hFFFF);

        // R10 + R5: vectored with slow memory, trap raised mid-entry
        ack_drive_i = 1'b1; ack_data_i = 16'hAB34; mem_wait = 3;
        raise(8'h04); addrq.delete();
        bound(16'h1000);
        raise(8'h40);
        wait_idle();
        check(addrq.size() == 2 && addrq[1] == VEC + 16'h0068, "R10 vector addr", addrq[1], VEC + 16'h0068);
        check(pending_o == 8'h40, "R5 kept flag", {8'h0, pending_o}, 16'h0040);
        bound(16'h0000); wait_idle();

        // R1: reserved bit ignored
        raise(8'h01); @(negedge clk);
        check(pending_o == 8'h00, "R1 reserved bit", {8'h0, pending_o}, 16'h0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule